// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for 32 pins organised as two banks of 16. Software drives outputs through separate write-one set and clear registers, so no read-modify-write is needed to change a single pin. A direction register chooses, per pin, whether the pin is driven. An input register shows the synchronized pin level for every pin, whatever its direction.

Each pin can report rising and falling edges. The two edge-enable masks are each changed through their own write-one set and clear registers. Detected edges on enabled pins are latched in a shared 32-bit status word that software clears by writing ones. Bits 15:0 feed the interrupt line of bank 0 and bits 31:16 feed the line of bank 1. Each line is gated by its own bit in a bank enable register. A pin configured as an output is sampled at its driven level, so its own output changes can raise interrupts.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input), `pinOe` is zero, and every other register, `pinOut` and both `bankIrq` lines read zero.
- R2: Writing word address 2 sets each output data bit whose write bit is 1. Zero bits leave their output unchanged. The output data reads back at address 1, and writes to address 1 are ignored.
- R3: Writing word address 3 clears each output data bit whose write bit is 1. Zero bits leave their output unchanged.
- R4: The direction register at address 0 is read/write. A 1 makes the pin an input and a 0 makes it an output. `pinOe` is the bitwise inverse of the direction register.
- R5: Address 4 returns the pin level after a two-stage synchronizer. A pin change applied before clock edge k is visible after edge k+1. Writes to address 4 are ignored.
- R6: The rising-edge enable mask reads at address 5. Writing ones at address 6 sets mask bits and writing ones at address 7 clears them.
- R7: The falling-edge enable mask reads at address 8. Writing ones at address 9 sets mask bits and writing ones at address 10 clears them.
- R8: The status word at address 11 latches an enabled edge one cycle after it shows in the input register. Writing ones to address 11 clears those bits. Edges on pins whose enable is off are not latched.
- R9: When an edge is latched in the same cycle that a clear write targets the same status bit, the bit stays set.
- R10: `bankIrq[b]` is high when any status bit of bank b (bank 0 = bits 15:0, bank 1 = bits 31:16) is set and bit b of the bank enable register (address 12) is 1.
- R11: A pin with direction 0 is sampled at its driven output value, not at `pinIn`, so changing its output raises its enabled edge interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Word address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| pinIn | input | 32 | Pad input levels |
| pinOut | output | 32 | Output data to pads |
| pinOe | output | 32 | Output enables to pads (1 = drive) |
| bankIrq | output | 2 | Per-bank interrupt lines |

## Verification
Two functions can fall on the same clock edge: latching a newly detected edge into the status word, and a software write-one-to-clear of that same bit. The bench sets a status bit with a rising edge. It then drops the pin and times a clear write so that it lands on the exact edge where the falling edge is latched, counting the two synchronizer stages. It expects the bit to read back as still set, and then confirms that a later plain clear does empty it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_DIR     = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT     = 4'd1;
  localparam logic [ADDR_W-1:0] A_SETOUT  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLROUT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_IN      = 4'd4;
  localparam logic [ADDR_W-1:0] A_RISE    = 4'd5;
  localparam logic [ADDR_W-1:0] A_SETRISE = 4'd6;
  localparam logic [ADDR_W-1:0] A_CLRRISE = 4'd7;
  localparam logic [ADDR_W-1:0] A_FALL    = 4'd8;
  localparam logic [ADDR_W-1:0] A_SETFALL = 4'd9;
  localparam logic [ADDR_W-1:0] A_CLRFALL = 4'd10;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'd11;
  localparam logic [ADDR_W-1:0] A_BANKEN  = 4'd12;

  typedef struct packed {
    logic wrDir;
    logic setOut;
    logic clrOut;
    logic setRise;
    logic clrRise;
    logic setFall;
    logic clrFall;
    logic clrStat;
    logic wrBankEn;
  } regStrobes_t;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (addr)
        A_DIR:     strobes.wrDir    = 1'b1;
        A_SETOUT:  strobes.setOut   = 1'b1;
        A_CLROUT:  strobes.clrOut   = 1'b1;
        A_SETRISE: strobes.setRise  = 1'b1;
        A_CLRRISE: strobes.clrRise  = 1'b1;
        A_SETFALL: strobes.setFall  = 1'b1;
        A_CLRFALL: strobes.clrFall  = 1'b1;
        A_STAT:    strobes.clrStat  = 1'b1;
        A_BANKEN:  strobes.wrBankEn = 1'b1;
        default:   strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_bank_pkg::*;
#(
  parameter int BANK_PINS   = 16,
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int DW = BANK_PINS * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wrData,
  input  logic [DW-1:0]     pinIn,
  output logic [DW-1:0]     rdData,
  output logic [DW-1:0]     dirBits,
  output logic [DW-1:0]     outBits,
  output logic [DW-1:0]     statBits,
  output logic [NUM_BANKS-1:0] bankEnBits,
  output logic [NUM_BANKS-1:0] bankIrq
);
  logic [DW-1:0] riseEn, fallEn;
  logic [DW-1:0] syncPipe [SYNC_STAGES];
  logic [DW-1:0] syncLvl, prevLvl, sampleLvl, edgeHits;

  // output pins loop back their driven value
  assign sampleLvl = (dirBits & pinIn) | (~dirBits & outBits);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirBits    <= '1;
      outBits    <= '0;
      riseEn     <= '0;
      fallEn     <= '0;
      bankEnBits <= '0;
    end else begin
      if (strobes.wrDir)    dirBits    <= wrData;
      if (strobes.setOut)   outBits    <= outBits | wrData;
      if (strobes.clrOut)   outBits    <= outBits & ~wrData;
      if (strobes.setRise)  riseEn     <= riseEn | wrData;
      if (strobes.clrRise)  riseEn     <= riseEn & ~wrData;
      if (strobes.setFall)  fallEn     <= fallEn | wrData;
      if (strobes.clrFall)  fallEn     <= fallEn & ~wrData;
      if (strobes.wrBankEn) bankEnBits <= wrData[NUM_BANKS-1:0];
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncPipe[s] <= '0;
        else if (s == 0) syncPipe[s] <= sampleLvl;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncLvl  = syncPipe[SYNC_STAGES-1];
  assign edgeHits = (syncLvl & ~prevLvl & riseEn) | (~syncLvl & prevLvl & fallEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl  <= '0;
      statBits <= '0;
    end else begin
      prevLvl  <= syncLvl;
      // a fresh edge wins over a clear aimed at the same bit
      statBits <= (statBits & ~(strobes.clrStat ? wrData : '0)) | edgeHits;
    end
  end

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq
      assign bankIrq[b] = bankEnBits[b] & (|statBits[b*BANK_PINS +: BANK_PINS]);
    end
  endgenerate

  always_comb begin
    unique case (addr)
      A_DIR:    rdData = dirBits;
      A_OUT:    rdData = outBits;
      A_IN:     rdData = syncLvl;
      A_RISE:   rdData = riseEn;
      A_FALL:   rdData = fallEn;
      A_STAT:   rdData = statBits;
      A_BANKEN: rdData = {{(DW-NUM_BANKS){1'b0}}, bankEnBits};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int BANK_PINS   = 16,
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int DW = BANK_PINS * NUM_BANKS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DW-1:0]        wrData,
  output logic [DW-1:0]        rdData,
  input  logic [DW-1:0]        pinIn,
  output logic [DW-1:0]        pinOut,
  output logic [DW-1:0]        pinOe,
  output logic [NUM_BANKS-1:0] bankIrq
);
  regStrobes_t           strobes;
  logic [DW-1:0]         dirBits, outBits, statBits;
  logic [NUM_BANKS-1:0]  bankEnBits;

  gpio_reg_decode u_decode (
    .wrEn(wrEn), .addr(addr), .strobes(strobes)
  );

  gpio_datapath #(
    .BANK_PINS(BANK_PINS), .NUM_BANKS(NUM_BANKS), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr),
    .wrData(wrData), .pinIn(pinIn), .rdData(rdData),
    .dirBits(dirBits), .outBits(outBits), .statBits(statBits),
    .bankEnBits(bankEnBits), .bankIrq(bankIrq)
  );

  assign pinOut = outBits;
  assign pinOe  = ~dirBits;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int DW        = 32,
  parameter int BANK_PINS = 16,
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DW-1:0]        wrData,
  input logic [DW-1:0]        outBits,
  input logic [DW-1:0]        dirBits,
  input logic [DW-1:0]        statBits,
  input logic [NUM_BANKS-1:0] bankIrq
);
  // R2
  set_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SETOUT) |=> ((outBits & $past(wrData)) == $past(wrData)));

  // R3
  clr_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_CLROUT) |=> ((outBits & $past(wrData)) == '0));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == A_SETOUT || addr == A_CLROUT)) |=> $stable(outBits));

  // R4
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_DIR) |=> (dirBits == $past(wrData)));

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == A_STAT) |=> ((statBits & $past(statBits)) == $past(statBits)));

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_irq_chk
      // R10
      irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
        bankIrq[b] |-> (|statBits[b*BANK_PINS +: BANK_PINS]));
    end
  endgenerate
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .DW(DW), .BANK_PINS(BANK_PINS), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .outBits(outBits), .dirBits(dirBits), .statBits(statBits), .bankIrq(bankIrq)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
  import gpio_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic [1:0]  bankIrq;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  gpio_bank_ctrl u_gpio_bank_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .bankIrq(bankIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    rd(A_DIR, rv);    chk("R1 dir", rv, 32'hFFFF_FFFF);
    chk("R1 pinOe", pinOe, 32'h0);
    chk("R1 pinOut", pinOut, 32'h0);
    chk("R1 irq", {30'h0, bankIrq}, 32'h0);
    rd(A_RISE, rv);   chk("R1 rise", rv, 32'h0);
    rd(A_FALL, rv);   chk("R1 fall", rv, 32'h0);
    rd(A_STAT, rv);   chk("R1 stat", rv, 32'h0);
    rd(A_BANKEN, rv); chk("R1 banken", rv, 32'h0);

    // R2 / R3 set and clear of output data
    wr(A_SETOUT, 32'hF00F_0003); rd(A_OUT, rv); chk("R2 set", rv, 32'hF00F_0003);
    wr(A_SETOUT, 32'h0000_0100); rd(A_OUT, rv); chk("R2 set keeps others", rv, 32'hF00F_0103);
    wr(A_SETOUT, 32'h0); chk("R2 zero write", pinOut, 32'hF00F_0103);
    wr(A_OUT, 32'h1234_5678); rd(A_OUT, rv); chk("R2 out write ignored", rv, 32'hF00F_0103);
    wr(A_CLROUT, 32'h300F_0001); rd(A_OUT, rv); chk("R3 clear", rv, 32'hC000_0102);
    wr(A_CLROUT, 32'h0); chk("R3 zero write", pinOut, 32'hC000_0102);
    wr(A_CLROUT, 32'hFFFF_FFFF); chk("R3 clear all", pinOut, 32'h0);

    // R4 direction
    wr(A_DIR, 32'h0000_FFFF); rd(A_DIR, rv); chk("R4 dir rd", rv, 32'h0000_FFFF);
    chk("R4 pinOe", pinOe, 32'hFFFF_0000);
    wr(A_DIR, 32'hFFFF_FFFF); chk("R4 pinOe inputs", pinOe, 32'h0);

    // R5 input sweep with synchronizer latency
    for (int i = 0; i < 32; i++) begin
      pinIn = 32'h1 << i;
      idle(3);
      rd(A_IN, rv); chk("R5 input level", rv, 32'h1 << i);
    end
    pinIn = 32'h0; idle(3);
    @(negedge clk); pinIn = 32'hA5A5_5A5A; addr = A_IN;
    @(negedge clk); #1 chk("R5 not yet visible", rdData, 32'h0);
    @(negedge clk); #1 chk("R5 visible after two edges", rdData, 32'hA5A5_5A5A);
    wr(A_IN, 32'h0); rd(A_IN, rv); chk("R5 write ignored", rv, 32'hA5A5_5A5A);
    pinIn = 32'h0; idle(4);

    // R6 / R7 enable masks
    wr(A_SETRISE, 32'hFFFF_00FF); wr(A_CLRRISE, 32'h0000_000F);
    rd(A_RISE, rv); chk("R6 rise mask", rv, 32'hFFFF_00F0);
    wr(A_SETFALL, 32'h00FF_0000); wr(A_CLRFALL, 32'h000F_0000);
    rd(A_FALL, rv); chk("R7 fall mask", rv, 32'h00F0_0000);
    wr(A_SETRISE, 32'hFFFF_FFFF); wr(A_CLRFALL, 32'hFFFF_FFFF);
    wr(A_BANKEN, 32'h3); rd(A_BANKEN, rv); chk("R10 banken rd", rv, 32'h3);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R8 / R10 per-pin edge sweep
    for (int i = 0; i < 32; i++) begin
      pinIn = 32'h1 << i; idle(4);
      rd(A_STAT, rv); chk("R8 rising latched", rv, 32'h1 << i);
      chk("R10 bank line", {30'h0, bankIrq}, (i < 16) ? 32'h1 : 32'h2);
      wr(A_STAT, 32'h1 << i);
      rd(A_STAT, rv); chk("R8 w1c", rv, 32'h0);
      pinIn = 32'h0; idle(4);
      rd(A_STAT, rv); chk("R8 fall disabled", rv, 32'h0);
    end

    // R7 falling edges, R10 gating
    wr(A_SETFALL, 32'h0001_0000);
    pinIn = 32'h0001_0000; idle(4); wr(A_STAT, 32'hFFFF_FFFF);
    pinIn = 32'h0; idle(4);
    rd(A_STAT, rv); chk("R7 falling latched", rv, 32'h0001_0000);
    wr(A_BANKEN, 32'h1);
    chk("R10 gated bank1", {30'h0, bankIrq}, 32'h0);
    wr(A_BANKEN, 32'h2);
    chk("R10 enabled bank1", {30'h0, bankIrq}, 32'h2);
    wr(A_STAT, 32'hFFFF_FFFF); wr(A_BANKEN, 32'h3);

    // R9 clear and edge on the same edge
    wr(A_SETFALL, 32'h0000_0020);
    pinIn = 32'h0000_0020; idle(4);
    rd(A_STAT, rv); chk("R9 setup bit set", rv, 32'h0000_0020);
    @(negedge clk); pinIn = 32'h0;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; addr = A_STAT; wrData = 32'h0000_0020;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    rd(A_STAT, rv); chk("R9 edge beats clear", rv, 32'h0000_0020);
    wr(A_STAT, 32'h0000_0020);
    rd(A_STAT, rv); chk("R9 later clear works", rv, 32'h0);

    // R11 output pin loopback
    wr(A_DIR, 32'hFFFF_FDFF);
    pinIn = 32'h0; idle(4); wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_SETOUT, 32'h0000_0200); idle(4);
    rd(A_STAT, rv); chk("R11 output raises edge", rv, 32'h0000_0200);
    rd(A_IN, rv); chk("R11 input shows driven level", rv, 32'h0000_0200);
    chk("R11 bank0 line", {30'h0, bankIrq}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule